// File: doc/BRIEF.md
# Matrix Remap Index Generator

The block walks a vector loop of up to three dimensions and emits one element offset per clock cycle. It is used beside an ordinary element-move engine, which has one generator for the source side and one for the destination side. When one side walks in straight order and the other walks in transposed order, a plain move becomes an n-way pack or unpack.

A single-cycle `start` pulse captures the walk order and the three dimension sizes. From the following cycle the block drives `valid` and emits one offset per cycle, for as many steps as the product of the sizes. `last` marks the final step, and the block then goes idle until the next start. In straight order the offsets count up from zero. In transposed order the x index advances slowly and the y index advances fast. The z index always advances slowest, and the offset is z·X·Y + y·X + x.

Top module: `remap_index_gen`

## Requirements
- R1: After reset `valid` and `last` are low and stay low until a start is accepted.
- R2: A start pulse sampled while idle makes `valid` high on the next cycle, with `offset` equal to 0.
- R3: With `order` = 0 (straight), step k of the walk emits offset k.
- R4: With `order` = 1 (transposed), step k emits z·X·Y + y·X + x, where y = k mod Y, x = (k div Y) mod X and z = k div (X·Y). For example, X=Y=3 gives 0 3 6 1 4 7 2 5 8.
- R5: A walk lasts exactly X·Y·Z consecutive cycles with `valid` high and no gaps.
- R6: `last` is high on the final step of a walk only, together with its offset, and never without `valid`.
- R7: A dimension size input of 0 acts as a size of 1.
- R8: While a walk is running, `start` and changes to `order`, `xdim`, `ydim` and `zdim` have no effect on the offsets emitted.
- R9: In the cycle after `last`, `valid` is low. A new start is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk when idle |
| order | input | 1 | 0 = straight, 1 = transposed (y fastest) |
| xdim | input | DIM_W | X size (0 means 1) |
| ydim | input | DIM_W | Y size (0 means 1) |
| zdim | input | DIM_W | Z size (0 means 1) |
| valid | output | 1 | Offset is valid this cycle |
| offset | output | 3*DIM_W | Remapped element offset |
| last | output | 1 | Final step of the walk |

## Verification
The bench builds the block with the default DIM_W of 3. It sweeps every combination of sizes 0 to 3 on all three axes in both orders, which covers the zero-size clamp, the degenerate single-step walks and the 2- and 3-way pack and unpack shapes. It also runs one 7×7×7 walk in each order, which reaches the largest offset of 342 and the counter wrap at the full width. Walks disturbed by a start pulse and by changed sizes during the run show that the captured configuration holds.

// File: rtl/remap_pkg.sv
// Shared types for the remap index generator.
// Assumes: a one-bit walk-order encoding, 0 straight and 1 transposed.
package remap_pkg;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_YX     = 1'b1
    } walk_order_t;

    localparam int NUM_AXES = 3;
endpackage

// File: rtl/remap_dim_fix.sv
// Clamps a dimension size so that a size of 0 is treated as 1 (R7).
// Assumes: an unsigned size of width W.
module remap_dim_fix #(
    parameter int W = 3
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] fixed
);
    // Replace zero with one; pass other values through.
    always_comb begin
        fixed = (raw == '0) ? W'(1) : raw;
    end
endmodule

// File: rtl/remap_wrap_cnt.sv
// Wrapping axis counter. It counts 0..lim while en is high and raises wrap
// on the enabled cycle at lim.
// Assumes: clr and en are never needed in the same cycle (clr has priority).
module remap_wrap_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic at_lim;
    assign at_lim = (cnt == lim);

    // Signal a carry to the next axis.
    always_comb begin
        wrap = en && at_lim;
    end

    // Advance or restart the axis index.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (en)     cnt <= at_lim ? '0 : cnt + W'(1);
    end

    // The index never passes its limit.
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> cnt <= lim);
endmodule

// File: rtl/remap_index_gen.sv
// Matrix remap index generator. A start pulse captures the order and sizes,
// and a walk then emits one offset per cycle for X*Y*Z steps. The inner,
// middle and outer counters are chained. The order chooses which of x and y
// is the inner axis.
// Assumes: a single-cycle start; a start during a walk is ignored.
module remap_index_gen
    import remap_pkg::*;
#(
    parameter int DIM_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 order,
    input  logic [DIM_W-1:0]     xdim,
    input  logic [DIM_W-1:0]     ydim,
    input  logic [DIM_W-1:0]     zdim,
    output logic                 valid,
    output logic [3*DIM_W-1:0]   offset,
    output logic                 last
);
    localparam int OFF_W = NUM_AXES * DIM_W;

    logic [DIM_W-1:0] raw_sz   [NUM_AXES];
    logic [DIM_W-1:0] fix_sz   [NUM_AXES];
    logic [DIM_W-1:0] sz_q     [NUM_AXES];  // captured x, y, z sizes
    logic [DIM_W-1:0] lim      [NUM_AXES];  // inner, middle, outer limits
    logic [DIM_W-1:0] cnt      [NUM_AXES];
    logic             wrap     [NUM_AXES];
    logic             en       [NUM_AXES];
    walk_order_t      order_q;
    logic             run_q;
    logic             accept;
    logic [DIM_W-1:0] x_idx, y_idx, z_idx;
    logic [OFF_W-1:0] total;

    assign raw_sz[0] = xdim;
    assign raw_sz[1] = ydim;
    assign raw_sz[2] = zdim;

    assign accept = start && !run_q;

    // One clamp and one counter per axis.
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        remap_dim_fix #(.W(DIM_W)) u_fix (
            .raw   (raw_sz[a]),
            .fixed (fix_sz[a])
        );
        if (a == 0) begin : g_inner
            assign en[a] = run_q;
        end else begin : g_chain
            assign en[a] = wrap[a-1];
        end
        remap_wrap_cnt #(.W(DIM_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (accept),
            .en    (en[a]),
            .lim   (lim[a]),
            .cnt   (cnt[a]),
            .wrap  (wrap[a])
        );
    end

    // Capture the configuration on an accepted start; end the walk on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            order_q <= ORD_LINEAR;
            for (int a = 0; a < NUM_AXES; a++) sz_q[a] <= DIM_W'(1);
        end else if (accept) begin
            run_q   <= 1'b1;
            order_q <= walk_order_t'(order);
            for (int a = 0; a < NUM_AXES; a++) sz_q[a] <= fix_sz[a];
        end else if (last) begin
            run_q   <= 1'b0;
        end
    end

    // Pick which axis runs fastest and set the counter limits.
    always_comb begin
        if (order_q == ORD_YX) begin
            lim[0] = sz_q[1] - DIM_W'(1);
            lim[1] = sz_q[0] - DIM_W'(1);
        end else begin
            lim[0] = sz_q[0] - DIM_W'(1);
            lim[1] = sz_q[1] - DIM_W'(1);
        end
        lim[2] = sz_q[2] - DIM_W'(1);
    end

    // Map the counters back to x, y, z and form the row-major offset.
    always_comb begin
        x_idx  = (order_q == ORD_YX) ? cnt[1] : cnt[0];
        y_idx  = (order_q == ORD_YX) ? cnt[0] : cnt[1];
        z_idx  = cnt[2];
        offset = OFF_W'(z_idx) * (OFF_W'(sz_q[0]) * OFF_W'(sz_q[1]))
               + OFF_W'(y_idx) * OFF_W'(sz_q[0])
               + OFF_W'(x_idx);
        total  = OFF_W'(sz_q[0]) * OFF_W'(sz_q[1]) * OFF_W'(sz_q[2]);
    end

    // Drive the output strobes.
    always_comb begin
        valid = run_q;
        last  = run_q && wrap[2];
    end

    assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);
    assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last) |=> valid);
    assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !valid);
    assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !valid) |=> (valid && offset == '0));
    assert_offset_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> offset < total);
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last) |=> $stable(total) && $stable(order_q));
endmodule

// File: tb/remap_index_gen_test.sv
module remap_index_gen_test;
    localparam int DIM_W = 3;
    localparam int OFF_W = 3 * DIM_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             order = 1'b0;
    logic [DIM_W-1:0] xdim = '0, ydim = '0, zdim = '0;
    logic             valid, last;
    logic [OFF_W-1:0] offset;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    remap_index_gen #(.DIM_W(DIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .order(order),
        .xdim(xdim), .ydim(ydim), .zdim(zdim),
        .valid(valid), .offset(offset), .last(last)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int s);
        return (s == 0) ? 1 : s;
    endfunction

    // Expected offset at step k (R3, R4).
    function automatic int exp_off(input bit ord, input int x, input int y, input int k);
        int xi, yi, zi;
        if (!ord) return k;
        yi = k % y;
        xi = (k / y) % x;
        zi = k / (x * y);
        return zi * x * y + yi * x + xi;
    endfunction

    // Run one walk; disturb asserts start and changes sizes mid-run (R8).
    task automatic walk(input bit ord, input int xs, input int ys, input int zs, input bit disturb);
        int x = eff(xs), y = eff(ys), z = eff(zs);
        int n = x * y * z;
        @(negedge clk);
        start = 1'b1; order = ord;
        xdim = DIM_W'(xs); ydim = DIM_W'(ys); zdim = DIM_W'(zs);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            check(valid == 1'b1, (k == 0) ? "R2" : "R5", int'(valid), 1);
            check(int'(offset) == exp_off(ord, x, y, k), ord ? "R4" : "R3",
                  int'(offset), exp_off(ord, x, y, k));
            check(last == (k == n - 1), "R6", int'(last), int'(k == n - 1));
            if (disturb && k == 0) begin
                start = 1'b1; order = ~ord;
                xdim = DIM_W'(2); ydim = DIM_W'(1); zdim = DIM_W'(3);
            end else if (disturb && k == 1) begin
                start = 1'b0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(valid == 1'b0, "R9", int'(valid), 0);
        check(last == 1'b0, "R9", int'(last), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, no start.
        repeat (3) begin
            @(negedge clk);
            check(valid == 1'b0, "R1", int'(valid), 0);
            check(last == 1'b0, "R1", int'(last), 0);
        end
        // Worked examples from R4: 3-way pack and 2-way unpack shapes.
        walk(1'b1, 3, 3, 1, 1'b0);
        walk(1'b1, 4, 2, 1, 1'b0);
        // Sweep including zero sizes (R7) in both orders.
        for (int o = 0; o < 2; o++)
            for (int xs = 0; xs < 4; xs++)
                for (int ys = 0; ys < 4; ys++)
                    for (int zs = 0; zs < 4; zs++)
                        walk(o[0], xs, ys, zs, 1'b0);
        // R8: disturbed walks.
        walk(1'b1, 3, 2, 2, 1'b1);
        walk(1'b0, 3, 3, 1, 1'b1);
        // Full-size walks.
        walk(1'b0, 7, 7, 7, 1'b0);
        walk(1'b1, 7, 7, 7, 1'b0);
        // R9: immediate restart after the idle cycle.
        walk(1'b1, 2, 3, 1, 1'b0);
        walk(1'b1, 2, 3, 1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule